// File: doc/BRIEF.md
# Binary-Tree Configuration Distribution Network

This block fans 32-bit configuration words out from a single root port to 2^LEVELS leaf processing elements through a binary tree of switch nodes. Each node steers a word to its left child, its right child, or to both. It decides this from a direction bit and a mask bit. Words cross the tree without registers, so every selected leaf sees a word in the same cycle on a shared data bus, and a per-leaf valid strobe marks which leaves are selected.

A word can carry its own route. The address and mask come with the command, so one pass reaches one leaf, a subtree, or every leaf. A word can also follow a route stored in the nodes. A link command writes the direction and mask registers in every node, stream words then follow that stored route with no address, and an unlink command closes it. A power command writes a per-leaf clock-enable bit for a chosen set of leaves. Status words that leaves raise come back to the root in the same cycle. Where several leaves report at once, each node gives its left subtree priority.

Top module: `cfgt_tree`

## Requirements
- R1: A send command (cmd_op 0) with cmd_mask all zero raises leaf_valid for exactly one leaf, in the same cycle. That leaf's index equals cmd_addr, read from MSB at the root to LSB at the last level, with bit 0 turning left and bit 1 turning right. leaf_data equals cmd_data.
- R2: A send command with a nonzero cmd_mask reaches every leaf whose index matches cmd_addr on all unmasked bit positions. An all-ones mask reaches all leaves.
- R3: At any level, a set mask bit forwards to both children whatever the direction bit is.
- R4: A link command (cmd_op 1) delivers nothing. From the next cycle on, it loads each node's direction register from cmd_addr and its mask register from cmd_mask, taking the bit for that node's level.
- R5: A stream command (cmd_op 2) while a link is open goes to the leaves chosen by the stored registers, and cmd_addr and cmd_mask have no effect on it. A send command still uses its own route while a link is open, and the stored route stays unchanged.
- R6: An unlink command (cmd_op 3) delivers nothing. A stream command after an unlink, or before any link since reset, reaches no leaf.
- R7: After reset, leaf_pwr is all ones. A power command (cmd_op 4) sets leaf_pwr of every leaf selected by cmd_addr/cmd_mask, using the R2 rule, to cmd_data[0] from the next cycle. Other leaves keep their value.
- R8: stat_valid is high in the same cycle that any leaf_stat_valid is high. stat_data and stat_src then come from the lowest-indexed reporting leaf, because each node prefers its left subtree.
- R9: Codes 5 to 7 on cmd_op, and any cycle with cmd_valid low, deliver nothing and change neither the stored route nor leaf_pwr.
- R10: In reset and right after it, leaf_valid and stat_valid are zero and no link is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present at the root |
| cmd_op | input | 3 | 0 send, 1 link, 2 stream, 3 unlink, 4 power |
| cmd_addr | input | LEVELS | Turn bits, MSB used at the root |
| cmd_mask | input | LEVELS | Both-ways bits, one per level |
| cmd_data | input | DW | Configuration word |
| leaf_valid | output | 2^LEVELS | Per-leaf delivery strobe |
| leaf_data | output | DW | Word seen by all selected leaves |
| leaf_pwr | output | 2^LEVELS | Per-leaf clock enable |
| leaf_stat_valid | input | 2^LEVELS | Leaf status request |
| leaf_stat_data | input | 2^LEVELS*DW | Leaf status words, leaf k at bits k*DW |
| stat_valid | output | 1 | Status present at the root |
| stat_data | output | DW | Winning status word |
| stat_src | output | LEVELS | Index of the winning leaf |

## Verification
Downward delivery and upward status collection share no logic, so they can happen in the same cycle. The bench drives a stream over an open link in the same cycle that two leaves on opposite halves of the tree raise status. It then checks that the leaf strobes follow the stored route and that the root reports the lower-indexed leaf. A send command issued while a link is open is also checked. It must reach its own target, and the next stream must still follow the stored route.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;
  typedef enum logic [2:0] {
    OP_SEND   = 3'd0,
    OP_LINK   = 3'd1,
    OP_STREAM = 3'd2,
    OP_UNLINK = 3'd3,
    OP_POWER  = 3'd4
  } cfgt_op_e;
endpackage

// File: rtl/cfgt_node.sv
module cfgt_node (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic load_dir,
  input  logic load_mask,
  input  logic use_cmd,
  input  logic cmd_dir,
  input  logic cmd_mask,
  input  logic in_act,
  output logic out_l,
  output logic out_r
);
  logic dir_q, mask_q, dir_d, mask_d;
  logic eff_dir, eff_mask;

  always_comb begin
    dir_d  = dir_q;
    mask_d = mask_q;
    if (load_en) begin
      dir_d  = load_dir;
      mask_d = load_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      dir_q  <= dir_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    eff_dir  = use_cmd ? cmd_dir  : dir_q;
    eff_mask = use_cmd ? cmd_mask : mask_q;
    out_l    = in_act & (eff_mask | ~eff_dir);
    out_r    = in_act & (eff_mask |  eff_dir);
  end

  // R1: nothing leaves a node that received nothing
  assert_fwd_needs_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_l || out_r) |-> in_act);
  // R3: a split happens only under a set mask
  assert_split_needs_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_l && out_r) |-> eff_mask);
endmodule

// File: rtl/cfgt_merge.sv
module cfgt_merge #(
  parameter int DW  = 32,
  parameter int SW  = 4,
  parameter int BIT = 0
) (
  input  logic          l_v,
  input  logic [DW-1:0] l_d,
  input  logic [SW-1:0] l_s,
  input  logic          r_v,
  input  logic [DW-1:0] r_d,
  input  logic [SW-1:0] r_s,
  output logic          o_v,
  output logic [DW-1:0] o_d,
  output logic [SW-1:0] o_s
);
  localparam logic [SW-1:0] RBIT = SW'(1) << BIT;

  always_comb begin
    o_v = l_v | r_v;
    if (l_v) begin
      o_d = l_d;
      o_s = l_s;
    end else begin
      o_d = r_d;
      o_s = r_s | RBIT;
    end
  end
endmodule

// File: rtl/cfgt_power.sv
module cfgt_power #(
  parameter int LEVELS = 4,
  localparam int LEAVES = 1 << LEVELS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LEVELS-1:0] wr_addr,
  input  logic [LEVELS-1:0] wr_mask,
  input  logic              wr_val,
  output logic [LEAVES-1:0] pwr
);
  logic [LEAVES-1:0] pwr_q, pwr_d, hit;

  always_comb begin
    for (int k = 0; k < LEAVES; k++)
      hit[k] = &(wr_mask | ~(wr_addr ^ LEVELS'(k)));
    pwr_d = pwr_q;
    if (wr_en)
      for (int k = 0; k < LEAVES; k++)
        if (hit[k]) pwr_d[k] = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= '1;
    else        pwr_q <= pwr_d;
  end

  assign pwr = pwr_q;

  for (genvar g = 0; g < LEAVES; g++) begin : g_chk
    // R7: a leaf clock enable only drops on a power write
    assert_pwr_drop_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_q[g]) |-> $past(wr_en));
  end
endmodule

// File: rtl/cfgt_tree.sv
module cfgt_tree
  import cfgt_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int DW     = 32,
  localparam int LEAVES = 1 << LEVELS,
  localparam int NODES  = 2 * LEAVES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [LEVELS-1:0]    cmd_addr,
  input  logic [LEVELS-1:0]    cmd_mask,
  input  logic [DW-1:0]        cmd_data,
  output logic [LEAVES-1:0]    leaf_valid,
  output logic [DW-1:0]        leaf_data,
  output logic [LEAVES-1:0]    leaf_pwr,
  input  logic [LEAVES-1:0]    leaf_stat_valid,
  input  logic [LEAVES*DW-1:0] leaf_stat_data,
  output logic                 stat_valid,
  output logic [DW-1:0]        stat_data,
  output logic [LEVELS-1:0]    stat_src
);
  logic is_send, is_link, is_stream, is_unlink, is_power;
  logic link_q, link_d, root_act;

  always_comb begin
    is_send   = cmd_valid && (cmd_op == OP_SEND);
    is_link   = cmd_valid && (cmd_op == OP_LINK);
    is_stream = cmd_valid && (cmd_op == OP_STREAM);
    is_unlink = cmd_valid && (cmd_op == OP_UNLINK);
    is_power  = cmd_valid && (cmd_op == OP_POWER);
    link_d    = link_q;
    if (is_link)        link_d = 1'b1;
    else if (is_unlink) link_d = 1'b0;
    root_act  = is_send || (is_stream && link_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_d;
  end

  // downward steering tree, heap indexed: node i has children 2i and 2i+1
  logic act [NODES-1:1];
  assign act[1] = root_act;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    for (genvar p = 0; p < (1 << lv); p++) begin : g_node
      localparam int I = (1 << lv) + p;
      cfgt_node u_node (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (is_link),
        .load_dir (cmd_addr[LEVELS-1-lv]),
        .load_mask(cmd_mask[LEVELS-1-lv]),
        .use_cmd  (is_send),
        .cmd_dir  (cmd_addr[LEVELS-1-lv]),
        .cmd_mask (cmd_mask[LEVELS-1-lv]),
        .in_act   (act[I]),
        .out_l    (act[2*I]),
        .out_r    (act[2*I+1])
      );
    end
  end

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    assign leaf_valid[k] = act[LEAVES+k];
  end
  assign leaf_data = cmd_data;

  // upward status merge, left subtree first
  logic              sv [NODES-1:1];
  logic [DW-1:0]     sd [NODES-1:1];
  logic [LEVELS-1:0] ss [NODES-1:1];

  for (genvar k = 0; k < LEAVES; k++) begin : g_src
    assign sv[LEAVES+k] = leaf_stat_valid[k];
    assign sd[LEAVES+k] = leaf_stat_data[k*DW +: DW];
    assign ss[LEAVES+k] = '0;
  end

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_up
    for (genvar p = 0; p < (1 << lv); p++) begin : g_mrg
      localparam int I = (1 << lv) + p;
      cfgt_merge #(.DW(DW), .SW(LEVELS), .BIT(LEVELS-1-lv)) u_merge (
        .l_v(sv[2*I]),   .l_d(sd[2*I]),   .l_s(ss[2*I]),
        .r_v(sv[2*I+1]), .r_d(sd[2*I+1]), .r_s(ss[2*I+1]),
        .o_v(sv[I]),     .o_d(sd[I]),     .o_s(ss[I])
      );
    end
  end

  assign stat_valid = sv[1];
  assign stat_data  = sd[1];
  assign stat_src   = ss[1];

  cfgt_power #(.LEVELS(LEVELS)) u_power (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (is_power),
    .wr_addr(cmd_addr),
    .wr_mask(cmd_mask),
    .wr_val (cmd_data[0]),
    .pwr    (leaf_pwr)
  );

  // R1: an unmasked send reaches exactly one leaf
  assert_unicast_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_send && cmd_mask == '0) |-> ($countones(leaf_valid) == 1));
  // R2: an all-ones mask reaches every leaf
  assert_broadcast_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_send && cmd_mask == '1) |-> (leaf_valid == '1));
  // R4, R6, R9: commands other than send and stream deliver nothing
  assert_quiet_ops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_send && !is_stream) |-> (leaf_valid == '0));
  // R6: no stream delivery without an open link
  assert_stream_needs_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stream && !link_q) |-> (leaf_valid == '0));
  // R8: the reported source is a leaf that is actually reporting
  assert_src_reports_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> leaf_stat_valid[stat_src]);
endmodule

// File: tb/cfgt_tree_test.sv
module cfgt_tree_test;
  localparam int LEVELS = 4;
  localparam int LEAVES = 1 << LEVELS;
  localparam int DW = 32;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [LEVELS-1:0] cmd_addr = '0, cmd_mask = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [LEAVES-1:0] leaf_valid, leaf_pwr;
  logic [DW-1:0] leaf_data, stat_data;
  logic [LEAVES-1:0] leaf_stat_valid = '0;
  logic [LEAVES*DW-1:0] leaf_stat_data;
  logic stat_valid;
  logic [LEVELS-1:0] stat_src;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cfgt_tree #(.LEVELS(LEVELS), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_mask(cmd_mask), .cmd_data(cmd_data),
    .leaf_valid(leaf_valid), .leaf_data(leaf_data), .leaf_pwr(leaf_pwr),
    .leaf_stat_valid(leaf_stat_valid), .leaf_stat_data(leaf_stat_data),
    .stat_valid(stat_valid), .stat_data(stat_data), .stat_src(stat_src)
  );

  for (genvar k = 0; k < LEAVES; k++) begin : g_sd
    assign leaf_stat_data[k*DW +: DW] = 32'h5000_0000 + k;
  end

  // {req, op, addr, mask, expected leaf_valid}
  typedef logic [4+3+4+4+16-1:0] vec_t;
  localparam vec_t VT [NV] = '{
    {4'd1,  3'd0, 4'b0110, 4'b0000, 16'h0040}, // R1 unicast leaf 6
    {4'd1,  3'd0, 4'b1011, 4'b0000, 16'h0800}, // R1 unicast leaf 11
    {4'd2,  3'd0, 4'b0000, 4'b1111, 16'hFFFF}, // R2 broadcast
    {4'd2,  3'd0, 4'b1010, 4'b0011, 16'h0F00}, // R2 subtree 8..11
    {4'd3,  3'd0, 4'b0100, 4'b1000, 16'h1010}, // R3 mask beats dir at root
    {4'd6,  3'd2, 4'b0000, 4'b0000, 16'h0000}, // R6 stream before link
    {4'd4,  3'd1, 4'b0011, 4'b0100, 16'h0000}, // R4 link silent
    {4'd5,  3'd2, 4'b1111, 4'b0000, 16'h0088}, // R5 stored route 3,7
    {4'd5,  3'd0, 4'b1111, 4'b0000, 16'h8000}, // R5 send overrides
    {4'd5,  3'd2, 4'b0000, 4'b1111, 16'h0088}, // R5 route kept
    {4'd9,  3'd5, 4'b0000, 4'b1111, 16'h0000}, // R9 unknown op
    {4'd9,  3'd2, 4'b0101, 4'b0000, 16'h0088}, // R9 route untouched
    {4'd6,  3'd3, 4'b0000, 4'b0000, 16'h0000}, // R6 unlink silent
    {4'd6,  3'd2, 4'b0000, 4'b0000, 16'h0000}, // R6 stream after unlink
    {4'd4,  3'd1, 4'b1100, 4'b0011, 16'h0000}, // R4 link 12..15
    {4'd5,  3'd2, 4'b0000, 4'b0000, 16'hF000}  // R5 stored route
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] op, input logic [3:0] a,
                       input logic [3:0] m, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_mask = m; cmd_data = d;
    #1;
  endtask

  initial begin
    #(8 * 5000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(leaf_valid == '0 && stat_valid == 1'b0, "R10 reset outputs", {leaf_valid, 15'd0, stat_valid}, 0);
    check(leaf_pwr == '1, "R7 reset power", leaf_pwr, 16'hFFFF);
    rst_n = 1'b1;
    drive(1'b1, 3'd2, 4'b0000, 4'b1111, 32'h1);
    check(leaf_valid == '0, "R10 no link after reset", leaf_valid, 0);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VT[i][26:24], VT[i][23:20], VT[i][19:16], 32'hA000_0000 + i);
      check(leaf_valid == VT[i][15:0], $sformatf("R%0d vec %0d", VT[i][30:27], i),
            leaf_valid, VT[i][15:0]);
      if (VT[i][15:0] != 0)
        check(leaf_data == 32'hA000_0000 + i, "R1 leaf_data", leaf_data, 32'hA000_0000 + i);
    end

    // R9: valid low delivers nothing
    drive(1'b0, 3'd0, 4'b0000, 4'b1111, 32'h0);
    check(leaf_valid == '0, "R9 valid low", leaf_valid, 0);

    // R7 power writes
    drive(1'b1, 3'd4, 4'b0000, 4'b0111, 32'h0);
    check(leaf_valid == '0, "R7 power silent", leaf_valid, 0);
    drive(1'b0, 3'd0, 4'b0000, 4'b0000, 32'h0);
    check(leaf_pwr == 16'hFF00, "R7 clear 0..7", leaf_pwr, 16'hFF00);
    drive(1'b1, 3'd4, 4'b0010, 4'b0000, 32'h1);
    drive(1'b1, 3'd6, 4'b0000, 4'b1111, 32'h0);
    check(leaf_pwr == 16'hFF04, "R7 set leaf 2", leaf_pwr, 16'hFF04);
    drive(1'b0, 3'd4, 4'b0000, 4'b1111, 32'h0);
    check(leaf_pwr == 16'hFF04, "R9 ignored ops keep power", leaf_pwr, 16'hFF04);

    // R8 status merge
    leaf_stat_valid = 16'h0220;
    drive(1'b0, 3'd0, 4'b0000, 4'b0000, 32'h0);
    check(stat_valid && stat_src == 4'd5 && stat_data == 32'h5000_0005, "R8 left first",
          {stat_src, stat_data}, {4'd5, 32'h5000_0005});
    leaf_stat_valid = 16'h0200;
    #1;
    check(stat_valid && stat_src == 4'd9 && stat_data == 32'h5000_0009, "R8 single right",
          {stat_src, stat_data}, {4'd9, 32'h5000_0009});
    leaf_stat_valid = 16'h0000;
    #1;
    check(!stat_valid, "R8 none", stat_valid, 0);

    // R5 + R8 concurrent: stream over link 12..15 with two reporters
    leaf_stat_valid = 16'h4008;
    drive(1'b1, 3'd2, 4'b0001, 4'b0000, 32'hCAFE_0001);
    check(leaf_valid == 16'hF000, "R5 stream during status", leaf_valid, 16'hF000);
    check(stat_valid && stat_src == 4'd3, "R8 status during stream", stat_src, 4'd3);
    leaf_stat_valid = '0;

    // R10 reset again clears link
    drive(1'b0, 3'd0, 4'b0000, 4'b0000, 32'h0);
    rst_n = 1'b0;
    #2;
    check(leaf_pwr == '1, "R10 power back to ones", leaf_pwr, 16'hFFFF);
    rst_n = 1'b1;
    drive(1'b1, 3'd2, 4'b0000, 4'b0000, 32'h0);
    check(leaf_valid == '0, "R6 link closed by reset", leaf_valid, 0);
    drive(1'b0, 3'd0, 4'b0000, 4'b0000, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule